// File: doc/BRIEF.md
# ATA Taskfile Sequencer

This block takes a whole ATA taskfile transfer and breaks it into single register cycles. A transfer is either a load (registers written to the device) or a read (registers fetched back). The block sits on top of a PIO cycle engine. It presents one register access at a time on a request/done handshake and waits for each access to finish before it issues the next. Register values returned by read cycles are gathered into a set of output fields that hold their values between transfers.

It keeps a copy of the device control byte it last wrote, so a load skips the control write when the value has not changed. For 48-bit addressing it also handles the high-order byte copies. On a load it writes the previous-value bytes before the current ones. On a read it sets the high-order select bit in device control, reads the shadow copies, and then writes the plain control value back.

Top module: `tf_seq`

## Requirements
- R1: Register codes on `reg_addr_o` are 1 feature/error, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 status, 4'hE device control. `reg_we_o` is 1 for a write and 0 for a read. Reads use only codes 1..7, and writes never use code 0 or 7.
- R2: A load begins with a write of the control byte to code 4'hE. This write happens only when the cached last-written control value is invalid or differs from the request's control byte, and after it the cache holds that byte.
- R3: When a load has both the address-valid and LBA48 flags set, the five high-order bytes are written next, to codes 1, 2, 3, 4, 5 in that order.
- R4: When a load has address-valid set, the current feature, sector count, LBA low, LBA mid and LBA high are then written, to codes 1..5 in that order.
- R5: The device register (code 6) is the last write of a load, and it is issued only when the device-valid flag is set.
- R6: A read fetches codes 7, 1, 2, 3, 4, 5, 6 in that order into status, error, sector count, LBA low, LBA mid, LBA high and device. Output fields keep their values until the same field is read again.
- R7: When a read has LBA48 set, it then writes control as the request's control byte with bit 7 set. It then reads codes 1..5 again into the five high-order output fields.
- R8: The LBA48 read ends with a write of the request's control byte, bit 7 as given, to code 4'hE, and the cache then holds that byte. A read without LBA48 leaves the cache unchanged.
- R9: Only one register request is outstanding at a time. `reg_req_o`, `reg_we_o`, `reg_addr_o` and `reg_wdata_o` stay constant until `reg_done_i` is seen, and the next request comes only after that.
- R10: `busy_o` rises in the cycle after a request is accepted and falls once the last access completes. Requests made while busy are ignored. The taskfile inputs are captured at acceptance. If load and read are requested together, the load wins.
- R11: After reset `busy_o` and `reg_req_o` are 0, all output fields are 0 and the control cache is invalid, so the first load always writes control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_req_i | input | 1 | Start a taskfile load |
| read_req_i | input | 1 | Start a taskfile read |
| addr_ok_i | input | 1 | Address bytes are valid |
| lba48_i | input | 1 | 48-bit addressing |
| dev_ok_i | input | 1 | Device byte is valid |
| ctl_i | input | 8 | Device control byte |
| dev_i | input | 8 | Device byte |
| feat_i | input | 8 | Feature byte |
| nsect_i | input | 8 | Sector count |
| lbal_i | input | 8 | LBA low |
| lbam_i | input | 8 | LBA mid |
| lbah_i | input | 8 | LBA high |
| hob_feat_i | input | 8 | High-order feature |
| hob_nsect_i | input | 8 | High-order sector count |
| hob_lbal_i | input | 8 | High-order LBA low |
| hob_lbam_i | input | 8 | High-order LBA mid |
| hob_lbah_i | input | 8 | High-order LBA high |
| busy_o | output | 1 | Transfer in progress |
| reg_req_o | output | 1 | Register cycle request |
| reg_we_o | output | 1 | Request is a write |
| reg_addr_o | output | 4 | Register code |
| reg_wdata_o | output | 8 | Write data |
| reg_done_i | input | 1 | Register cycle complete |
| reg_rdata_i | input | 8 | Read data, valid with done |
| status_o | output | 8 | Status read |
| error_o | output | 8 | Error read |
| nsect_o | output | 8 | Sector count read |
| lbal_o | output | 8 | LBA low read |
| lbam_o | output | 8 | LBA mid read |
| lbah_o | output | 8 | LBA high read |
| dev_o | output | 8 | Device read |
| hob_error_o | output | 8 | High-order error read |
| hob_nsect_o | output | 8 | High-order sector count read |
| hob_lbal_o | output | 8 | High-order LBA low read |
| hob_lbam_o | output | 8 | High-order LBA mid read |
| hob_lbah_o | output | 8 | High-order LBA high read |

## Verification
A corrupted step counter shows up quickly on the register handshake. The next request carries a register code or write direction out of order, or the transfer ends with too few or too many cycles. This is caught on the transfer where it happens. A stale or wrong control cache stays hidden until the next load, where it shows as a control write that is missing or extra. The bench keeps its own cache model across transfers of both kinds. A wrong capture index puts a byte in the wrong output field, and this shows once the read transfer ends.

// File: rtl/tf_seq_pkg.sv
package tf_seq_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 4;
  localparam int unsigned N_RES = 12;

  localparam logic [AW-1:0] A_FEAT = 4'h1;
  localparam logic [AW-1:0] A_DEV  = 4'h6;
  localparam logic [AW-1:0] A_STAT = 4'h7;
  localparam logic [AW-1:0] A_CTL  = 4'hE;

  typedef struct packed {
    logic          addr_ok;
    logic          lba48;
    logic          dev_ok;
    logic [DW-1:0] ctl;
    logic [DW-1:0] dev;
    logic [DW-1:0] hob_lbah;
    logic [DW-1:0] hob_lbam;
    logic [DW-1:0] hob_lbal;
    logic [DW-1:0] hob_nsect;
    logic [DW-1:0] hob_feat;
    logic [DW-1:0] lbah;
    logic [DW-1:0] lbam;
    logic [DW-1:0] lbal;
    logic [DW-1:0] nsect;
    logic [DW-1:0] feat;
  } tf_t;
endpackage

// File: rtl/tf_seq_step.sv
module tf_seq_step
  import tf_seq_pkg::*;
#(
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned HOB_BIT = 7
) (
  input  logic              is_load_i,
  input  logic [STEP_W-1:0] step_i,
  input  tf_t               tf_i,
  input  logic              cache_hit_i,
  output logic              valid_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              cap_en_o,
  output logic [3:0]        cap_idx_o,
  output logic              ctl_upd_o,
  output logic              last_o
);
  localparam int unsigned LOAD_LAST = 11;
  localparam int unsigned READ_LAST = 13;

  function automatic logic [DW-1:0] pick(tf_t t, logic hob, int unsigned i);
    case (i)
      1: pick = hob ? t.hob_feat  : t.feat;
      2: pick = hob ? t.hob_nsect : t.nsect;
      3: pick = hob ? t.hob_lbal  : t.lbal;
      4: pick = hob ? t.hob_lbam  : t.lbam;
      default: pick = hob ? t.hob_lbah : t.lbah;
    endcase
  endfunction

  int unsigned s;
  logic [DW-1:0] hob_mask;
  assign s = int'(step_i);
  assign hob_mask = DW'(1) << HOB_BIT;

  always_comb begin
    valid_o   = 1'b0;
    we_o      = 1'b0;
    addr_o    = '0;
    wdata_o   = '0;
    cap_en_o  = 1'b0;
    cap_idx_o = '0;
    ctl_upd_o = 1'b0;
    if (is_load_i) begin
      last_o = (s == LOAD_LAST);
      we_o   = 1'b1;
      if (s == 0) begin
        valid_o   = !cache_hit_i;
        addr_o    = A_CTL;
        wdata_o   = tf_i.ctl;
        ctl_upd_o = 1'b1;
      end else if (s <= 5) begin
        valid_o = tf_i.addr_ok && tf_i.lba48;
        addr_o  = AW'(s);
        wdata_o = pick(tf_i, 1'b1, s);
      end else if (s <= 10) begin
        valid_o = tf_i.addr_ok;
        addr_o  = AW'(s - 5);
        wdata_o = pick(tf_i, 1'b0, s - 5);
      end else begin
        valid_o = tf_i.dev_ok && (s == LOAD_LAST);
        addr_o  = A_DEV;
        wdata_o = tf_i.dev;
      end
    end else begin
      last_o = (s == READ_LAST);
      if (s == 0) begin
        valid_o  = 1'b1;
        addr_o   = A_STAT;
        cap_en_o = 1'b1;
      end else if (s <= 6) begin
        valid_o   = 1'b1;
        addr_o    = AW'(s);
        cap_en_o  = 1'b1;
        cap_idx_o = 4'(s);
      end else if (s == 7) begin
        valid_o = tf_i.lba48;
        we_o    = 1'b1;
        addr_o  = A_CTL;
        wdata_o = tf_i.ctl | hob_mask;
      end else if (s <= 12) begin
        valid_o   = tf_i.lba48;
        addr_o    = AW'(s - 7);
        cap_en_o  = 1'b1;
        cap_idx_o = 4'(s - 1);
      end else begin
        valid_o   = tf_i.lba48 && (s == READ_LAST);
        we_o      = 1'b1;
        addr_o    = A_CTL;
        wdata_o   = tf_i.ctl;
        ctl_upd_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tf_seq_ctl_cache.sv
module tf_seq_ctl_cache
  import tf_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] cmp_i,
  output logic          hit_o
);
  logic          vld_q;
  logic [DW-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      val_q <= '0;
    end else if (upd_i) begin
      vld_q <= 1'b1;
      val_q <= din_i;
    end
  end

  assign hit_o = vld_q && (val_q == cmp_i);
endmodule

// File: rtl/tf_seq_capture.sv
module tf_seq_capture
  import tf_seq_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [3:0]               idx_i,
  input  logic [DW-1:0]            din_i,
  output logic [N_RES-1:0][DW-1:0] res_o
);
  for (genvar g = 0; g < N_RES; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_o[g] <= '0;
      else if (en_i && (idx_i == 4'(g))) res_o[g] <= din_i;
    end
  end
endmodule

// File: rtl/tf_seq.sv
module tf_seq
  import tf_seq_pkg::*;
#(
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned HOB_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_req_i,
  input  logic          read_req_i,
  input  logic          addr_ok_i,
  input  logic          lba48_i,
  input  logic          dev_ok_i,
  input  logic [7:0]    ctl_i,
  input  logic [7:0]    dev_i,
  input  logic [7:0]    feat_i,
  input  logic [7:0]    nsect_i,
  input  logic [7:0]    lbal_i,
  input  logic [7:0]    lbam_i,
  input  logic [7:0]    lbah_i,
  input  logic [7:0]    hob_feat_i,
  input  logic [7:0]    hob_nsect_i,
  input  logic [7:0]    hob_lbal_i,
  input  logic [7:0]    hob_lbam_i,
  input  logic [7:0]    hob_lbah_i,
  output logic          busy_o,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [3:0]    reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  input  logic          reg_done_i,
  input  logic [7:0]    reg_rdata_i,
  output logic [7:0]    status_o,
  output logic [7:0]    error_o,
  output logic [7:0]    nsect_o,
  output logic [7:0]    lbal_o,
  output logic [7:0]    lbam_o,
  output logic [7:0]    lbah_o,
  output logic [7:0]    dev_o,
  output logic [7:0]    hob_error_o,
  output logic [7:0]    hob_nsect_o,
  output logic [7:0]    hob_lbal_o,
  output logic [7:0]    hob_lbam_o,
  output logic [7:0]    hob_lbah_o
);
  logic              run_q, load_q;
  logic [STEP_W-1:0] step_q;
  tf_t               tf_q, tf_d;
  logic              st_valid, st_we, st_cap, st_upd, st_last, cache_hit;
  logic [AW-1:0]     st_addr;
  logic [DW-1:0]     st_wdata;
  logic [3:0]        st_idx;
  logic              accept, advance, xfer_done;
  logic [N_RES-1:0][DW-1:0] res;

  assign tf_d = '{addr_ok: addr_ok_i, lba48: lba48_i, dev_ok: dev_ok_i,
                  ctl: ctl_i, dev: dev_i,
                  hob_lbah: hob_lbah_i, hob_lbam: hob_lbam_i, hob_lbal: hob_lbal_i,
                  hob_nsect: hob_nsect_i, hob_feat: hob_feat_i,
                  lbah: lbah_i, lbam: lbam_i, lbal: lbal_i,
                  nsect: nsect_i, feat: feat_i};

  assign accept    = !run_q && (load_req_i || read_req_i);
  assign xfer_done = reg_req_o && reg_done_i;
  // skipped steps cost one idle cycle each
  assign advance   = run_q && (!st_valid || reg_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      load_q <= 1'b0;
      step_q <= '0;
      tf_q   <= '0;
    end else if (accept) begin
      run_q  <= 1'b1;
      load_q <= load_req_i;
      step_q <= '0;
      tf_q   <= tf_d;
    end else if (advance) begin
      if (st_last) run_q <= 1'b0;
      else step_q <= step_q + 1'b1;
    end
  end

  tf_seq_step #(.STEP_W(STEP_W), .HOB_BIT(HOB_BIT)) i_step (
    .is_load_i  (load_q),
    .step_i     (step_q),
    .tf_i       (tf_q),
    .cache_hit_i(cache_hit),
    .valid_o    (st_valid),
    .we_o       (st_we),
    .addr_o     (st_addr),
    .wdata_o    (st_wdata),
    .cap_en_o   (st_cap),
    .cap_idx_o  (st_idx),
    .ctl_upd_o  (st_upd),
    .last_o     (st_last)
  );

  tf_seq_ctl_cache i_cache (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (xfer_done && st_upd),
    .din_i (tf_q.ctl),
    .cmp_i (tf_q.ctl),
    .hit_o (cache_hit)
  );

  tf_seq_capture i_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (xfer_done && st_cap),
    .idx_i (st_idx),
    .din_i (reg_rdata_i),
    .res_o (res)
  );

  assign busy_o      = run_q;
  assign reg_req_o   = run_q && st_valid;
  assign reg_we_o    = st_we;
  assign reg_addr_o  = st_addr;
  assign reg_wdata_o = st_wdata;

  assign status_o    = res[0];
  assign error_o     = res[1];
  assign nsect_o     = res[2];
  assign lbal_o      = res[3];
  assign lbam_o      = res[4];
  assign lbah_o      = res[5];
  assign dev_o       = res[6];
  assign hob_error_o = res[7];
  assign hob_nsect_o = res[8];
  assign hob_lbal_o  = res[9];
  assign hob_lbam_o  = res[10];
  assign hob_lbah_o  = res[11];
endmodule

// File: rtl/tf_seq_chk.sv
module tf_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_req_i,
  input logic       read_req_i,
  input logic       busy_o,
  input logic       reg_req_o,
  input logic       reg_we_o,
  input logic [3:0] reg_addr_o,
  input logic [7:0] reg_wdata_o,
  input logic       reg_done_i
);
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_done_i |=> reg_req_o && $stable(reg_addr_o) &&
                                 $stable(reg_wdata_o) && $stable(reg_we_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !reg_req_o);

  p_busy_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && (load_req_i || read_req_i) |=> busy_o);

  p_busy_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_done_i |=> busy_o);

  p_read_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_we_o |-> reg_addr_o >= 4'h1 && reg_addr_o <= 4'h7);

  p_write_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_we_o |-> reg_addr_o != 4'h0 && reg_addr_o != 4'h7);
endmodule

bind tf_seq tf_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_req_i (load_req_i),
  .read_req_i (read_req_i),
  .busy_o     (busy_o),
  .reg_req_o  (reg_req_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .reg_wdata_o(reg_wdata_o),
  .reg_done_i (reg_done_i)
);

// File: tb/test_tf_seq.sv
module test_tf_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       load_req = 0, read_req = 0, addr_ok = 0, lba48 = 0, dev_ok = 0;
  logic [7:0] ctl_in = 0, dev_in = 0;
  logic [7:0] cur_in [1:5];
  logic [7:0] hob_in [1:5];
  logic       busy, req, we, done = 0;
  logic [3:0] addr;
  logic [7:0] wdata, rdata = 0;
  logic [7:0] res [0:11];

  tf_seq i_tf_seq (
    .clk_i(clk), .rst_ni(rst_n), .load_req_i(load_req), .read_req_i(read_req),
    .addr_ok_i(addr_ok), .lba48_i(lba48), .dev_ok_i(dev_ok),
    .ctl_i(ctl_in), .dev_i(dev_in),
    .feat_i(cur_in[1]), .nsect_i(cur_in[2]), .lbal_i(cur_in[3]),
    .lbam_i(cur_in[4]), .lbah_i(cur_in[5]),
    .hob_feat_i(hob_in[1]), .hob_nsect_i(hob_in[2]), .hob_lbal_i(hob_in[3]),
    .hob_lbam_i(hob_in[4]), .hob_lbah_i(hob_in[5]),
    .busy_o(busy), .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_done_i(done), .reg_rdata_i(rdata),
    .status_o(res[0]), .error_o(res[1]), .nsect_o(res[2]), .lbal_o(res[3]),
    .lbam_o(res[4]), .lbah_o(res[5]), .dev_o(res[6]), .hob_error_o(res[7]),
    .hob_nsect_o(res[8]), .hob_lbal_o(res[9]), .hob_lbam_o(res[10]),
    .hob_lbah_o(res[11])
  );

  int checks = 0, fails = 0;
  bit [12:0] log_q[$];
  bit [12:0] exp_q[$];
  logic [7:0] exp_res [0:11];

  // device model
  logic [7:0] d_cur [0:7];
  logic [7:0] d_hob [0:7];
  bit         d_hobsel = 0;
  // bench control cache model
  bit         mc_vld = 0;
  logic [7:0] mc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  initial begin
    int wc = 0;
    for (int i = 0; i < 8; i++) begin d_cur[i] = 8'(i * 17 + 3); d_hob[i] = 8'(i * 29 + 1); end
    d_cur[7] = 8'h50;
    forever begin
      @(negedge clk);
      if (done) done = 0;
      else if (req) begin
        if (wc > 0) wc--;
        else begin
          if (we) begin
            log_q.push_back({1'b1, addr, wdata});
            if (addr >= 1 && addr <= 5) begin d_hob[addr] = d_cur[addr]; d_cur[addr] = wdata; end
            else if (addr == 6) d_cur[6] = wdata;
            else if (addr == 4'hE) d_hobsel = wdata[7];
          end else begin
            log_q.push_back({1'b0, addr, 8'h00});
            if (addr >= 1 && addr <= 5) rdata = d_hobsel ? d_hob[addr] : d_cur[addr];
            else rdata = d_cur[addr[2:0]];
          end
          done = 1;
          wc = $urandom_range(2, 0);
        end
      end
    end
  end

  task automatic build_exp(input bit ld);
    exp_q.delete();
    if (ld) begin
      if (!mc_vld || mc != ctl_in) exp_q.push_back({1'b1, 4'hE, ctl_in});
      mc = ctl_in; mc_vld = 1;
      if (addr_ok && lba48) for (int i = 1; i <= 5; i++) exp_q.push_back({1'b1, 4'(i), hob_in[i]});
      if (addr_ok) for (int i = 1; i <= 5; i++) exp_q.push_back({1'b1, 4'(i), cur_in[i]});
      if (dev_ok) exp_q.push_back({1'b1, 4'h6, dev_in});
    end else begin
      exp_q.push_back({1'b0, 4'h7, 8'h00});
      exp_res[0] = d_cur[7];
      for (int i = 1; i <= 6; i++) begin
        exp_q.push_back({1'b0, 4'(i), 8'h00});
        exp_res[i] = (i <= 5 && d_hobsel) ? d_hob[i] : d_cur[i];
      end
      if (lba48) begin
        exp_q.push_back({1'b1, 4'hE, ctl_in | 8'h80});
        for (int i = 1; i <= 5; i++) begin
          exp_q.push_back({1'b0, 4'(i), 8'h00});
          exp_res[6 + i] = d_hob[i];
        end
        exp_q.push_back({1'b1, 4'hE, ctl_in});
        mc = ctl_in; mc_vld = 1;
      end
    end
  endtask

  task automatic randomize_inputs();
    addr_ok = 1'($urandom); lba48 = 1'($urandom); dev_ok = 1'($urandom);
    ctl_in = 8'($urandom) & 8'h06; dev_in = 8'($urandom);
    for (int i = 1; i <= 5; i++) begin cur_in[i] = 8'($urandom); hob_in[i] = 8'($urandom); end
  endtask

  task automatic do_op(input bit ld, input bit both, input bit poke, input string tag);
    int n = 0;
    build_exp(ld);
    log_q.delete();
    @(negedge clk);
    load_req = ld; read_req = !ld || both;
    @(negedge clk);
    load_req = 0; read_req = 0;
    chk(busy === 1'b1, "R10", {tag, " busy after accept"}, busy, 1);
    if (poke) begin
      load_req = 1; read_req = 1;
      randomize_inputs();
      @(negedge clk);
      load_req = 0; read_req = 0;
    end
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R10", {tag, " transfer finished"}, n, 5000);
    repeat (4) @(negedge clk);
    chk(log_q.size() == exp_q.size(), "R9",
        {tag, " cycle count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp_q[i], ld ? "R1 R2 R3 R4 R5" : "R1 R6 R7 R8",
          {tag, " cycle {we,code,data}"}, log_q[i], exp_q[i]);
    for (int i = 0; i < 12; i++)
      chk(res[i] === exp_res[i], i < 7 ? "R6" : "R7",
          {tag, " result field"}, res[i], exp_res[i]);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 12; i++) exp_res[i] = 0;
    for (int i = 1; i <= 5; i++) begin cur_in[i] = 0; hob_in[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy === 0 && req === 0, "R11", "reset busy/req", {busy, req}, 0);
    for (int i = 0; i < 12; i++) chk(res[i] === 8'h00, "R11", "reset field", res[i], 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11: cache invalid after reset, control 0 still written
    ctl_in = 8'h00; addr_ok = 1; lba48 = 1; dev_ok = 1; dev_in = 8'hE0;
    for (int i = 1; i <= 5; i++) begin cur_in[i] = 8'(8'h10 + i); hob_in[i] = 8'(8'hA0 + i); end
    do_op(1, 0, 0, "R11 first load");
    // R2: same control again, skip
    addr_ok = 1; lba48 = 0; dev_ok = 0;
    do_op(1, 0, 0, "R2 cache hit");
    // nothing to write at all
    addr_ok = 0; lba48 = 0; dev_ok = 0;
    do_op(1, 0, 0, "R5 empty load");
    // R7 R8: LBA48 read, then load with same control skips control
    ctl_in = 8'h02; lba48 = 1;
    do_op(0, 0, 0, "R7 R8 lba48 read");
    addr_ok = 0; lba48 = 0; dev_ok = 1; dev_in = 8'h40;
    do_op(1, 0, 0, "R8 cache after read");
    // plain read does not touch cache
    ctl_in = 8'h04; lba48 = 0;
    do_op(0, 0, 0, "R6 short read");
    dev_ok = 0;
    do_op(1, 0, 0, "R8 short read keeps cache");
    // R10: both together -> load; poke while busy
    randomize_inputs();
    do_op(1, 1, 1, "R10 both requests");
    randomize_inputs();
    do_op(0, 0, 1, "R10 ignored while busy");

    for (int k = 0; k < 60; k++) begin
      randomize_inputs();
      do_op(1'($urandom), 0, 1'($urandom), "random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule